// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the station side of a two-wire management link to one or more PHYs. A host presents a command (read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data) and pulses a start strobe. The block makes the management clock from the system clock with a programmable divider. It then shifts the whole management frame out on a tri-state data line, with the output value and the output enable kept as separate signals. Read data comes back on the 16-bit result port when the done pulse appears.

Each command says whether a 32-bit all-ones preamble goes in front of the frame, so the preamble can be left out when every PHY on the link tolerates that. On reads the block checks the PHY's turnaround zero. If it sees a one instead, it raises an error flag and puts a full preamble on the next command by itself, whatever that command asks for, so that the PHY can resynchronize.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, mdc, mdio_oe and ta_err are all 0.
- R2: While busy, mdc starts low and each low or high phase lasts exactly Heff system clocks, where Heff is half_div, or MIN_HALF (default 5) when half_div is smaller. While not busy, mdc stays low.
- R3: At the mdc rising edges after any preamble, the frame bits come in this order: start bits 0 then 1, then opcode 1,0 for a read (cmd_read=1) or 0,1 for a write, then cmd_phy MSB first, then cmd_reg MSB first.
- R4: With cmd_preamble=1, 32 bits of 1 with mdio_oe=1 come before the start bits. With cmd_preamble=0 and no pending resync, the frame has exactly 32 bits and begins with the start bits.
- R5: On a write, the turnaround bits are 1 then 0, followed by cmd_wdata MSB first, and mdio_oe is 1 for every bit of the frame.
- R6: On a read, mdio_oe is 1 up to the last register-address bit and 0 from the first turnaround bit through the last data bit. At done, rd_data holds the 16 mdio_i values sampled at the data-bit rising edges, MSB first.
- R7: ta_err is set when mdio_i is 1 at the rising edge of the second turnaround bit of a read. It is cleared when the next command is accepted, and it stays 0 after writes and after reads with a correct turnaround.
- R8: After a turnaround error, the next accepted command carries a 32-bit preamble even when cmd_preamble=0. After a frame with a preamble, the choice goes back to cmd_preamble.
- R9: busy rises in the cycle after an accepted start and stays high for exactly 2·Heff·N cycles, where N is 32 or 64 bits. done is a one-cycle pulse in the first cycle after busy falls. A start while busy is ignored.
- R10: While busy, mdio_o and mdio_oe change only in the cycle in which mdc falls.
- R11: When not busy, mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start strobe, accepted only while idle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_preamble | input | 1 | 1 = send 32-bit preamble before the frame |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Write data |
| half_div | input | DIV_W | Half-period of mdc in system clocks (floored at MIN_HALF) |
| mdio_i | input | 1 | Sensed management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven when enabled |
| mdio_oe | output | 1 | Output enable of the data line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| ta_err | output | 1 | Read turnaround error flag |

## Verification
Every result is due at a known cycle count after the start strobe. busy shows in the first cycle after acceptance. Each mdc phase lasts Heff cycles. A frame bit is stable from its mdc falling edge to the next falling edge. done, rd_data and ta_err become valid together 2·Heff·N cycles after acceptance. The bench samples on the falling system clock edge. It records mdio_o and mdio_oe at each observed mdc rise, drives the PHY reply just after each observed mdc fall, counts busy cycles against 2·Heff·N, and reads done, rd_data and ta_err in the first cycle in which busy is low. The next sample then checks that done is gone and the line is released.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Bit index over preamble (0..31) and frame (32..63).
  localparam int IDX_W = 6;
  typedef logic [IDX_W-1:0] idx_t;

  localparam idx_t FRAME_FIRST = idx_t'(32);
  localparam idx_t TA1_IDX     = idx_t'(46);
  localparam idx_t TA2_IDX     = idx_t'(47);
  localparam idx_t DATA_IDX    = idx_t'(48);
  localparam idx_t LAST_IDX    = idx_t'(63);

  // 32-bit frame, transmitted from bit 31 downwards.
  function automatic logic [31:0] build_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] regad, input logic [15:0] wd);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
            (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
  endfunction

  function automatic logic bit_val(input idx_t i, input logic [31:0] frame);
    return (i < FRAME_FIRST) ? 1'b1 : frame[~i[4:0]];
  endfunction

  function automatic logic bit_oe(input idx_t i, input logic rd);
    return !(rd && (i >= TA1_IDX));
  endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  localparam logic [DIV_W-1:0] MINV = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] hc;
  logic             wrap;

  assign eff     = (half_div < MINV) ? MINV : half_div;
  assign wrap    = run && (hc >= eff - 1'b1);
  assign rise_tk = wrap && !mdc;
  assign fall_tk = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hc  <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      hc  <= '0;
      mdc <= ~mdc;
    end else begin
      hc  <= hc + 1'b1;
    end
  end

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst) !run |=> !mdc);
  // R2
  mdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> (mdc == $past(mdc)));
endmodule

// File: rtl/mdio_tx_seq.sv
module mdio_tx_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_start,
  input  logic        cmd_read,
  input  logic        cmd_preamble,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  input  logic        resync_req,
  input  logic        fall_tk,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output idx_t        bit_idx,
  output logic        is_read,
  output logic        accept,
  output logic        accept_pre
);
  logic [31:0] frame_q;
  logic [31:0] frame_new;
  idx_t        first_idx;
  idx_t        next_idx;
  logic        last_bit;

  assign accept     = cmd_start && !busy;
  assign accept_pre = accept && (cmd_preamble || resync_req);
  assign frame_new  = build_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
  assign first_idx  = (cmd_preamble || resync_req) ? '0 : FRAME_FIRST;
  assign next_idx   = bit_idx + 1'b1;
  assign last_bit   = (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      bit_idx <= '0;
      is_read <= 1'b0;
      frame_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        frame_q <= frame_new;
        is_read <= cmd_read;
        bit_idx <= first_idx;
        mdio_o  <= bit_val(first_idx, frame_new);
        mdio_oe <= 1'b1;
      end else if (busy && fall_tk) begin
        if (last_bit) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= next_idx;
          mdio_o  <= bit_val(next_idx, frame_q);
          mdio_oe <= bit_oe(next_idx, is_read);
        end
      end
    end
  end

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_start) |=> ($stable(frame_q) && $stable(is_read)));
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && is_read && (bit_idx >= TA1_IDX)) |-> !mdio_oe);
  // R10
  mdio_change_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(fall_tk)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: rtl/mdio_rd_capture.sv
module mdio_rd_capture
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        mdio_i,
  input  logic        rise_tk,
  input  logic        accept,
  input  logic        accept_pre,
  input  logic        busy,
  input  logic        is_read,
  input  idx_t        bit_idx,
  output logic [15:0] rd_data,
  output logic        ta_err,
  output logic        resync_req
);
  logic smp_en;
  assign smp_en = busy && is_read && rise_tk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      ta_err     <= 1'b0;
      resync_req <= 1'b0;
    end else if (accept) begin
      ta_err <= 1'b0;
      if (accept_pre) resync_req <= 1'b0;
    end else if (smp_en) begin
      if ((bit_idx == TA2_IDX) && mdio_i) begin
        ta_err     <= 1'b1;
        resync_req <= 1'b1;
      end
      if (bit_idx >= DATA_IDX) rd_data <= {rd_data[14:0], mdio_i};
    end
  end

  // R7
  ta_err_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ta_err) |-> is_read);
  // R8
  resync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(resync_req) |-> $past(accept_pre));
  // R6
  rd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rd_data));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic             cmd_read,
  input  logic             cmd_preamble,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic [15:0]      cmd_wdata,
  input  logic [DIV_W-1:0] half_div,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             ta_err
);
  logic rise_tk, fall_tk;
  logic resync_req, is_read, accept, accept_pre;
  idx_t bit_idx;

  mdc_gen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .half_div(half_div),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk));

  mdio_tx_seq u_tx (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_preamble(cmd_preamble), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .resync_req(resync_req), .fall_tk(fall_tk),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bit_idx(bit_idx), .is_read(is_read), .accept(accept), .accept_pre(accept_pre));

  mdio_rd_capture u_rx (
    .clk(clk), .rst(rst), .mdio_i(mdio_i), .rise_tk(rise_tk),
    .accept(accept), .accept_pre(accept_pre), .busy(busy), .is_read(is_read),
    .bit_idx(bit_idx), .rd_data(rd_data), .ta_err(ta_err), .resync_req(resync_req));
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, cmd_read = 0, cmd_preamble = 0;
  logic [4:0] cmd_phy = 0, cmd_reg = 0;
  logic [15:0] cmd_wdata = 0;
  logic [7:0] half_div = 0;
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, busy, done, ta_err;
  logic [15:0] rd_data;

  int checks = 0, failures = 0;
  bit finished = 0;
  bit resync_m = 0;
  logic [63:0] sbit, soe;

  always #2 clk = ~clk;

  mdio_master uut (.clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_preamble(cmd_preamble), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .half_div(half_div), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy), .done(done),
    .rd_data(rd_data), .ta_err(ta_err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic run_cmd(input bit rd, input bit pre, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd, input bit ta2,
                         input logic [15:0] rdv, input int heff, input bit poke);
    int p, nrise, len, badhalf, badchg, bcnt, smp;
    bit forced;
    logic pm, po, poe;
    logic [31:0] expf;
    logic [4:0] gphy, greg;
    logic [15:0] gdat;
    int badpre, badoe, badwr;
    forced = !pre && resync_m;
    p = (pre || resync_m) ? 32 : 0;
    expf = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
    cmd_read = rd; cmd_preamble = pre; cmd_phy = phy; cmd_reg = ra; cmd_wdata = wd;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == 1'b1 && mdio_oe == 1'b1, "R9 busy after start", {busy, mdio_oe}, 2'b11);
    nrise = 0; len = 1; badhalf = 0; badchg = 0; bcnt = 1; smp = 0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    sbit = '0; soe = '0;
    while (1) begin
      @(negedge clk);
      smp++;
      if (poke && smp == 30) begin cmd_start = 1'b1; cmd_phy = ~phy; cmd_read = ~rd; end
      if (poke && smp == 31) cmd_start = 1'b0;
      if (!busy) begin
        if (len != heff) badhalf++;
        break;
      end
      bcnt++;
      if (mdc != pm) begin
        if (len != heff) badhalf++;
        len = 1;
        if (mdc) begin
          if (nrise < 64) begin sbit[nrise] = mdio_o; soe[nrise] = mdio_oe; end
          nrise++;
        end else if (rd) begin
          if (nrise - p == 15) mdio_i = ta2;
          else if (nrise - p >= 16 && nrise - p < 32) mdio_i = rdv[31 - (nrise - p)];
          else mdio_i = 1'b1;
        end
      end else len++;
      if ((mdio_o != po || mdio_oe != poe) && !(pm && !mdc)) badchg++;
      pm = mdc; po = mdio_o; poe = mdio_oe;
    end
    chk(done == 1'b1, "R9 done after busy", done, 1);
    chk(bcnt == 2 * heff * (p + 32), "R9 busy length", bcnt, 2 * heff * (p + 32));
    chk(badhalf == 0, "R2 mdc half period", badhalf, 0);
    chk(badchg == 0, "R10 mdio change off falling edge", badchg, 0);
    chk(nrise == p + 32, forced ? "R8 forced preamble" : "R4 bit count", nrise, p + 32);
    badpre = 0;
    for (int k = 0; k < p; k++) if (!sbit[k] || !soe[k]) badpre++;
    chk(badpre == 0, "R4 preamble ones", badpre, 0);
    chk({sbit[p], sbit[p+1], sbit[p+2], sbit[p+3]} == expf[31:28], "R3 start/opcode",
        {sbit[p], sbit[p+1], sbit[p+2], sbit[p+3]}, expf[31:28]);
    for (int k = 0; k < 5; k++) begin
      gphy[4-k] = sbit[p+4+k];
      greg[4-k] = sbit[p+9+k];
    end
    chk(gphy == phy, "R3 phy address", gphy, phy);
    chk(greg == ra, "R3 register address", greg, ra);
    badoe = 0; badwr = 0;
    for (int k = 0; k < 32; k++) begin
      if (soe[p+k] != (!rd || k < 14)) badoe++;
      if (!rd && sbit[p+k] != expf[31-k]) badwr++;
    end
    chk(badoe == 0, rd ? "R6 read release" : "R5 write drive", badoe, 0);
    if (!rd) chk(badwr == 0, "R5 write ta/data", badwr, 0);
    if (rd) chk(rd_data == rdv, "R6 read data", rd_data, rdv);
    chk(ta_err == (rd && ta2), "R7 ta_err", ta_err, rd && ta2);
    mdio_i = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && mdio_oe == 1'b0 && mdc == 1'b0, "R11 idle after done",
        {done, mdio_oe, mdc}, 0);
    if (poke) begin
      @(negedge clk);
      chk(busy == 1'b0, "R9 start while busy ignored", busy, 0);
    end
    if (p == 32) resync_m = 0;
    if (rd && ta2) resync_m = 1;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int hlist [3] = '{0, 5, 7};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk({busy, done, mdc, mdio_oe, ta_err} == 5'b0, "R1 reset state",
        {busy, done, mdc, mdio_oe, ta_err}, 0);
    @(negedge clk);
    foreach (hlist[h]) begin
      int heff;
      half_div = 8'(hlist[h]);
      heff = (hlist[h] < 5) ? 5 : hlist[h];
      for (int i = 0; i < 4; i++) begin
        logic [4:0] ph, rg;
        logic [15:0] wd;
        ph = 5'((i * 7 + 3 + h) & 31);
        rg = 5'((i * 11 + h * 5) & 31);
        wd = 16'hA5C3 ^ 16'(i * 16'h1111 + h);
        run_cmd(0, 1, ph, rg, wd, 0, 16'h0, heff, 0);
        run_cmd(1, 0, ~ph, rg, 16'h0, 0, ~wd, heff, 0);
        run_cmd(1, 0, ph, ~rg, 16'h0, 1, wd, heff, 0);
        run_cmd(0, 0, ph, rg, ~wd, 0, 16'h0, heff, 0);
        run_cmd(0, 0, ~ph, ~rg, wd, 0, 16'h0, heff, 0);
      end
    end
    half_div = 8'd6;
    run_cmd(1, 1, 5'h12, 5'h07, 16'h0, 0, 16'h8001, 6, 1);
    finish_run();
  end
endmodule